// File: doc/BRIEF.md
# Dual Parallel-Port GPIO Controller

This block gives a processor 48 general-purpose lines through an 8-byte register window. The lines are split between two identical units. Each unit has three byte-wide ports, called A, B and C, and one control register. Software sets the directions with a mode-set command. Port A and port B each change direction as a whole byte. Port C is split into an upper nibble and a lower nibble, and each nibble has its own direction. Writes to a port offset load that port's output latch. Reads return a mix of live pin levels and latch values, chosen bit by bit by direction.

A control write with bit 7 clear does not reload directions. It sets or clears one bit of port C's latch. Only simple latched I/O is supported. Mode bits that would select strobed operation are accepted and ignored.

Top module: `dual_pio`

## Requirements
- R1: After reset every output-enable is 0, every output latch (and so every `pin_out` bit) is 0, and `rdata` is 0x00.
- R2: Offsets 0, 1 and 2 address ports A, B and C of unit 0, and offset 3 is unit 0 control. Offsets 4, 5 and 6 address ports A, B and C of unit 1, and offset 7 is unit 1 control. Port P of unit U drives `pin_out[(U*3+P)*8 +: 8]`, where A=0, B=1 and C=2.
- R3: A write to a port offset stores `wdata` in that port's latch. `pin_out` shows the new value from the clock edge that takes the write.
- R4: A control write with bit 7 = 1 is a mode-set. Bit 4 sets the direction of port A and bit 1 sets the direction of port B. A bit value of 1 means input (`pin_oe` = 0) and 0 means output (`pin_oe` = 1).
- R5: In a mode-set, bit 3 sets the direction of port C bits 7:4 and bit 0 sets the direction of port C bits 3:0, with 1 meaning input.
- R6: A mode-set clears all three latches of its own unit to zero. Bits 6, 5 and 2 of the mode-set word have no effect.
- R7: A mode-set of 0x80 makes all 24 lines of that unit outputs.
- R8: A read with `rd_en` at a port offset returns a byte on `rdata` in the following cycle. Each input bit shows `pin_in` and each output bit shows its latch. `rdata` holds its value when no read is made.
- R9: A read of a control offset returns 0x00.
- R10: A control write with bit 7 = 0 sets port C latch bit `wdata[3:1]` to `wdata[0]`. It changes no other latch bit and no direction.
- R11: A write to one unit changes neither the latches nor the directions of the other unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_out | output | 48 | Output latch value for each line |
| pin_oe | output | 48 | Output enable for each line |
| pin_in | input | 48 | Pin level for each line |

## Verification
Some rules are checked by the assertions on every cycle. Directions change only on a mode-set. Latches hold when no write is made. A mode-set leaves its unit's latches zero. A set/reset touches at most one port C bit, and that bit takes the requested value. Control reads return zero, and `rdata` stays stable between reads.

Other behaviours can only be shown by the bench scenarios. These are the exact direction decode of each mode bit, the per-bit merge of pin levels and latches on a read, the address map across both units, the isolation between the units, and the fact that the unused mode bits are ignored.

// File: rtl/dual_pio_pkg.sv
package dual_pio_pkg;
  localparam int BYTE_W   = 8;
  localparam int HALF_W   = BYTE_W / 2;
  localparam int PORTS    = 3;
  localparam int SLOT_N   = 4;
  localparam int LINES_U  = PORTS * BYTE_W;
  localparam logic [1:0] CTRL_SLOT = 2'd3;
  localparam int MS_FLAG  = 7;
  localparam int MS_A_IN  = 4;
  localparam int MS_CH_IN = 3;
  localparam int MS_B_IN  = 1;
  localparam int MS_CL_IN = 0;
endpackage

// File: rtl/pio_unit.sv
module pio_unit
  import dual_pio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           slot,
  input  logic [BYTE_W-1:0]    wdata,
  output logic [LINES_U-1:0]   lat_o,
  output logic [LINES_U-1:0]   oe_o
);
  logic [BYTE_W-1:0] lat_q [PORTS];
  logic [BYTE_W-1:0] oe_q  [PORTS];

  wire ctl_wr  = wr_en && (slot == CTRL_SLOT);
  wire mode_wr = ctl_wr && wdata[MS_FLAG];
  wire bit_wr  = ctl_wr && !wdata[MS_FLAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < PORTS; p++) begin
        lat_q[p] <= '0;
        oe_q[p]  <= '0;
      end
    end else if (mode_wr) begin
      for (int p = 0; p < PORTS; p++) lat_q[p] <= '0;
      oe_q[0] <= {BYTE_W{~wdata[MS_A_IN]}};
      oe_q[1] <= {BYTE_W{~wdata[MS_B_IN]}};
      oe_q[2] <= {{HALF_W{~wdata[MS_CH_IN]}}, {HALF_W{~wdata[MS_CL_IN]}}};
    end else if (bit_wr) begin
      lat_q[2][wdata[3:1]] <= wdata[0];
    end else if (wr_en) begin
      lat_q[slot] <= wdata;
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_flat
    assign lat_o[p*BYTE_W +: BYTE_W] = lat_q[p];
    assign oe_o[p*BYTE_W +: BYTE_W]  = oe_q[p];
  end

  assert_dir_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !mode_wr |=> $stable(oe_o))
    else $error("direction changed without mode-set");

  assert_modeset_clear_R6: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (lat_o == '0))
    else $error("latches not cleared by mode-set");

  assert_latch_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(lat_o))
    else $error("latch changed without write");

  assert_bitset_R10: assert property (@(posedge clk) disable iff (rst)
    bit_wr |=> ($countones(lat_o ^ $past(lat_o)) <= 1) && $stable(oe_o)
               && (lat_o[2*BYTE_W + $past(wdata[3:1])] == $past(wdata[0])))
    else $error("bit set/reset misbehaved");
endmodule

// File: rtl/pio_readmux.sv
module pio_readmux
  import dual_pio_pkg::*;
#(
  parameter int UNITS  = 2,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [UNITS*LINES_U-1:0] lat,
  input  logic [UNITS*LINES_U-1:0] oe,
  input  logic [UNITS*LINES_U-1:0] pins,
  output logic [BYTE_W-1:0]        rdata
);
  localparam int UW = (ADDR_W > 2) ? ADDR_W - 2 : 1;

  logic [UW-1:0]     unit_idx;
  logic [1:0]        slot;
  logic [BYTE_W-1:0] sel_lat, sel_oe, sel_pin, merged;

  always_comb begin
    unit_idx = '0;
    if (ADDR_W > 2) unit_idx = UW'(addr >> 2);
    slot    = addr[1:0];
    sel_lat = '0;
    sel_oe  = '0;
    sel_pin = '0;
    if (slot != CTRL_SLOT && int'(unit_idx) < UNITS) begin
      sel_lat = lat[(int'(unit_idx)*PORTS + int'(slot))*BYTE_W +: BYTE_W];
      sel_oe  = oe[(int'(unit_idx)*PORTS + int'(slot))*BYTE_W +: BYTE_W];
      sel_pin = pins[(int'(unit_idx)*PORTS + int'(slot))*BYTE_W +: BYTE_W];
    end
    merged = (sel_oe & sel_lat) | (~sel_oe & sel_pin);
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= merged;
  end

  assert_ctrl_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[1:0] == CTRL_SLOT) |=> (rdata == '0))
    else $error("control read not zero");

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata))
    else $error("rdata changed without read");
endmodule

// File: rtl/dual_pio.sv
module dual_pio
  import dual_pio_pkg::*;
#(
  parameter int UNITS = 2,
  localparam int ADDR_W = $clog2(UNITS * SLOT_N),
  localparam int LINES  = UNITS * LINES_U
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [LINES-1:0]  pin_out,
  output logic [LINES-1:0]  pin_oe,
  input  logic [LINES-1:0]  pin_in
);
  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    wire hit = wr_en && (int'(addr >> 2) == u);
    pio_unit u_unit (
      .clk   (clk),
      .rst   (rst),
      .wr_en (hit),
      .slot  (addr[1:0]),
      .wdata (wdata),
      .lat_o (pin_out[u*LINES_U +: LINES_U]),
      .oe_o  (pin_oe[u*LINES_U +: LINES_U])
    );
  end

  pio_readmux #(.UNITS(UNITS), .ADDR_W(ADDR_W)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .addr  (addr),
    .lat   (pin_out),
    .oe    (pin_oe),
    .pins  (pin_in),
    .rdata (rdata)
  );
endmodule

// File: tb/sim_dual_pio.sv
`timescale 1ns/1ps
module sim_dual_pio;
  logic        clk = 0;
  logic        rst = 1;
  logic [2:0]  addr = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] pin_out, pin_oe, pin_in = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_pio u0 (.clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
               .wdata(wdata), .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe),
               .pin_in(pin_in));

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic t_reset();
    chk("R1 oe", pin_oe, 48'h0);
    chk("R1 out", pin_out, 48'h0);
    chk("R1 rdata", {40'h0, rdata}, 48'h0);
  endtask

  task automatic t_all_out();
    wr(3, 8'h80); wr(7, 8'h80);
    chk("R7 all outputs", pin_oe, {48{1'b1}});
  endtask

  task automatic t_map();
    wr(0, 8'h11); wr(1, 8'h22); wr(2, 8'h33);
    wr(4, 8'h44); wr(5, 8'h55); wr(6, 8'h66);
    chk("R2 R3 map", pin_out, 48'h665544_332211);
  endtask

  task automatic t_dir_decode();
    wr(3, 8'h90);
    chk("R4 portA in", pin_oe[23:0], 24'hFFFF00);
    chk("R6 clear own unit", pin_out, 48'h665544_000000);
    wr(3, 8'h82);
    chk("R4 portB in", pin_oe[23:0], 24'hFF00FF);
    wr(3, 8'h88);
    chk("R5 C high in", pin_oe[23:0], 24'h0FFFFF);
    wr(3, 8'h81);
    chk("R5 C low in", pin_oe[23:0], 24'hF0FFFF);
    chk("R11 unit1 untouched", pin_oe[47:24], 24'hFFFFFF);
  endtask

  task automatic t_ignored();
    wr(7, 8'hE4);
    chk("R6 ignored bits", pin_oe[47:24], 24'hFFFFFF);
    chk("R6 clear unit1", pin_out[47:24], 24'h0);
  endtask

  task automatic t_read();
    logic [7:0] d;
    wr(3, 8'h88);
    wr(2, 8'hA5);
    pin_in[23:16] = 8'h3C;
    rd(2, d);
    chk("R8 C mixed read", {40'h0, d}, {40'h0, 8'h35});
    wr(3, 8'h92);
    pin_in[7:0] = 8'h5A;
    rd(0, d);
    chk("R8 A input read", {40'h0, d}, {40'h0, 8'h5A});
    wr(5, 8'hC3);
    rd(5, d);
    chk("R8 B output read", {40'h0, d}, {40'h0, 8'hC3});
    rd(3, d);
    chk("R9 ctrl read", {40'h0, d}, 48'h0);
    rd(7, d);
    chk("R9 ctrl read u1", {40'h0, d}, 48'h0);
    @(negedge clk);
    chk("R8 hold", {40'h0, rdata}, 48'h0);
  endtask

  task automatic t_bitset();
    logic [47:0] oe_b;
    wr(7, 8'h80);
    wr(6, 8'h0F);
    oe_b = pin_oe;
    wr(7, 8'h0F);
    chk("R10 set bit7", pin_out[47:40], 8'h8F);
    wr(7, 8'h02);
    chk("R10 clear bit1", pin_out[47:40], 8'h8D);
    chk("R10 dirs kept", pin_oe, oe_b);
    chk("R11 unit0 latches", pin_out[23:0], 24'h0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_all_out();
    t_map();
    t_dir_decode();
    t_ignored();
    t_read();
    t_bitset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule